// File: doc/BRIEF.md
# Disk Sector Transfer FIFO Controller

This block is the data path between a host byte port and the serial-side byte stream of a floppy-style disk controller. It holds a 16-byte FIFO and follows the controller's three phases: command, execution and result. While a command is being taken in, the FIFO is shut. When execution starts, the FIFO is emptied so that no byte left over from an earlier command reaches the disk or the host. The block then moves one sector in the direction chosen at that moment.

For a write, the host fills the FIFO and the disk side asks for one byte at a time. If the disk side asks while the FIFO is empty, the transfer has underrun. The block does not stop in the middle of the sector. It sends zero bytes up to the sector length and then the CRC-16 of what it actually sent, so the sector on the medium stays well formed. For a read, a byte that arrives from the disk while the FIFO is full is an overrun. That byte is dropped and the transfer stops, but the host still drains what the FIFO holds. The result phase starts only when the disk side has finished and the FIFO is empty.

Requests to the host follow a programmable threshold. A configuration input selects whether the request appears on the DMA request line or on the plain host request line.

Top module: `fdc_xfer_fifo`

## Requirements
- R1: After reset, `phase` is 0 (command), both error flags are 0, `fifo_level` is 0, and `host_req`, `dma_req` and `disk_ovalid` are low.
- R2: The phase codes are 0 for command, 1 for execution and 2 for result. In the command phase, host writes and disk input bytes are ignored, so `fifo_level` stays 0.
- R3: An `exec_start` pulse in any phase empties the FIFO and clears both error flags. It also captures `xfer_write` (1 = write to disk) and `sector_len` (at least 1). The phase is 1 from the next cycle on.
- R4: In a write, a host byte is accepted when the FIFO is not full, no underrun has occurred, and fewer than `sector_len` bytes have been accepted. Each `disk_need` pulse takes the oldest byte, which appears on `disk_odata` with `disk_ovalid` high in the following cycle.
- R5: After `sector_len` sector bytes, the next two `disk_need` pulses return the CRC. The high byte comes first, then the low byte. The CRC is CRC-16 with polynomial 0x1021 and preset 0xFFFF, bits taken most significant first, no final inversion, computed over every sector byte sent (pad bytes included).
- R6: A `disk_need` pulse while the FIFO is empty in a write sets `underrun_flag`. That byte and every remaining sector byte are sent as 0x00, followed by the CRC. Host writes are ignored from then on.
- R7: In a read, a disk byte is stored when the FIFO is not full. A byte arriving while the FIFO holds 16 sets `overrun_flag`; that byte and every later disk byte are dropped.
- R8: In a read, `host_rdata` shows the oldest stored byte and a `host_rd` pulse removes it. The host can drain all stored bytes after the disk side has stopped.
- R9: The phase becomes 2 once the disk side has finished and `fifo_level` is 0. The disk side has finished when the CRC low byte has been sent, when `sector_len` bytes have been received, or when an overrun has occurred. A `result_done` pulse then returns the phase to 0. The error flags hold their values until the next `exec_start`.
- R10: A request exists only in phase 1. In a write, it is raised when `fifo_level` is at most `req_thresh`, bytes are still owed and there is no underrun. In a read, it is raised when `fifo_level` exceeds `req_thresh`, or when the disk side has finished and the FIFO is not empty. With `dma_mode` high the request drives `dma_req` only; otherwise it drives `host_req` only.
- R11: `fifo_level` never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_start | input | 1 | Pulse: execution phase begins |
| xfer_write | input | 1 | Direction captured at exec_start, 1 = write to disk |
| dma_mode | input | 1 | Selects the DMA request line for requests |
| req_thresh | input | 4 | Request threshold in bytes |
| sector_len | input | 10 | Sector length in bytes, captured at exec_start |
| result_done | input | 1 | Pulse: result phase finished |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Oldest FIFO byte |
| host_req | output | 1 | Request to host (non-DMA) |
| dma_req | output | 1 | DMA request |
| disk_need | input | 1 | Disk side wants the next byte (write) |
| disk_odata | output | 8 | Byte to disk |
| disk_ovalid | output | 1 | disk_odata valid |
| disk_ivalid | input | 1 | Byte from disk valid (read) |
| disk_idata | input | 8 | Byte from disk |
| phase | output | 2 | 0 command, 1 execution, 2 result |
| overrun_flag | output | 1 | Sticky overrun status |
| underrun_flag | output | 1 | Sticky underrun status |
| fifo_level | output | 5 | Bytes held in the FIFO |

## Verification
The assertions check on every cycle that the FIFO is empty throughout the command and result phases. They also check that an execution start leaves the FIFO empty with both flags clear, that the level never passes 16, and that a dropped overrun byte does not change the level. The remaining cycle checks are that the underrun flag stays set, that requests and disk output appear only during execution, and that the DMA line stays low outside DMA mode. The byte order to the disk, the zero padding, the CRC value, the order of data drained by the host and the cycle in which the result phase begins depend on whole sector sequences. Only the bench's random and directed scenarios, checked against its own CRC and queue model, can show those.

// File: rtl/fdc_xfer_pkg.sv
package fdc_xfer_pkg;

  typedef enum logic [1:0] {
    PH_CMD    = 2'd0,
    PH_EXEC   = 2'd1,
    PH_RESULT = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    DS_IDLE,
    DS_DATA,
    DS_PAD,
    DS_CRC_HI,
    DS_CRC_LO,
    DS_DONE
  } disk_st_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  // Fold one byte into the running CRC-16, most significant bit first.
  function automatic logic [15:0] crc_add_byte(input logic [15:0] crc_in,
                                               input logic [7:0]  din);
    logic [15:0] r;
    r = crc_in ^ {din, 8'h00};
    for (int i = 0; i < 8; i++) begin
      if (r[15]) r = {r[14:0], 1'b0} ^ CRC_POLY;
      else       r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/fdc_xfer_ram_fifo.sv
module fdc_xfer_ram_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push,
  input  logic                     pop,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     empty,
  output logic                     full
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/fdc_disk_seq.sv
module fdc_disk_seq
  import fdc_xfer_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic [LEN_W-1:0] len,
  input  logic             need,
  input  logic             ivalid,
  input  logic             fifo_empty,
  input  logic             fifo_full,
  input  logic [7:0]       fifo_head,
  output logic             pop,
  output logic             push,
  output logic             und_ev,
  output logic             ovr_ev,
  output logic             done,
  output logic [7:0]       odata,
  output logic             ovalid
);
  disk_st_e         st;
  logic             dir_q;
  logic [LEN_W-1:0] len_q, cnt;
  logic [15:0]      crc_q;
  logic             last_byte;
  logic [7:0]       out_byte;

  assign last_byte = (cnt == len_q - 1'b1);
  assign done      = (st == DS_DONE);

  always_comb begin
    pop    = 1'b0;
    push   = 1'b0;
    und_ev = 1'b0;
    ovr_ev = 1'b0;
    if (!start && st == DS_DATA) begin
      if (dir_q) begin
        if (need) begin
          if (fifo_empty) und_ev = 1'b1;
          else            pop    = 1'b1;
        end
      end else if (ivalid) begin
        if (fifo_full) ovr_ev = 1'b1;
        else           push   = 1'b1;
      end
    end
  end

  assign out_byte = pop ? fifo_head : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= DS_IDLE;
      dir_q  <= 1'b0;
      len_q  <= '0;
      cnt    <= '0;
      crc_q  <= CRC_SEED;
      odata  <= '0;
      ovalid <= 1'b0;
    end else if (start) begin
      st     <= DS_DATA;
      dir_q  <= is_write;
      len_q  <= len;
      cnt    <= '0;
      crc_q  <= CRC_SEED;
      ovalid <= 1'b0;
    end else begin
      ovalid <= 1'b0;
      case (st)
        DS_DATA: begin
          if (dir_q) begin
            if (need) begin
              ovalid <= 1'b1;
              odata  <= out_byte;
              crc_q  <= crc_add_byte(crc_q, out_byte);
              cnt    <= cnt + 1'b1;
              if (last_byte)   st <= DS_CRC_HI;
              else if (und_ev) st <= DS_PAD;
            end
          end else begin
            if (push) begin
              cnt <= cnt + 1'b1;
              if (last_byte) st <= DS_DONE;
            end
            if (ovr_ev) st <= DS_DONE;
          end
        end
        DS_PAD: if (need) begin
          ovalid <= 1'b1;
          odata  <= 8'h00;
          crc_q  <= crc_add_byte(crc_q, 8'h00);
          cnt    <= cnt + 1'b1;
          if (last_byte) st <= DS_CRC_HI;
        end
        DS_CRC_HI: if (need) begin
          ovalid <= 1'b1;
          odata  <= crc_q[15:8];
          st     <= DS_CRC_LO;
        end
        DS_CRC_LO: if (need) begin
          ovalid <= 1'b1;
          odata  <= crc_q[7:0];
          st     <= DS_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fdc_xfer_fifo.sv
module fdc_xfer_fifo
  import fdc_xfer_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       exec_start,
  input  logic                       xfer_write,
  input  logic                       dma_mode,
  input  logic [$clog2(DEPTH)-1:0]   req_thresh,
  input  logic [LEN_W-1:0]           sector_len,
  input  logic                       result_done,
  input  logic                       host_wr,
  input  logic [7:0]                 host_wdata,
  input  logic                       host_rd,
  output logic [7:0]                 host_rdata,
  output logic                       host_req,
  output logic                       dma_req,
  input  logic                       disk_need,
  output logic [7:0]                 disk_odata,
  output logic                       disk_ovalid,
  input  logic                       disk_ivalid,
  input  logic [7:0]                 disk_idata,
  output logic [1:0]                 phase,
  output logic                       overrun_flag,
  output logic                       underrun_flag,
  output logic [$clog2(DEPTH):0]     fifo_level
);
  localparam int CW = $clog2(DEPTH) + 1;

  phase_e           phase_q;
  logic             dir_q, und_q, ovr_q;
  logic [LEN_W-1:0] len_q, host_cnt;
  logic             in_exec, owed;

  // Named internal events, visible to the bound checker.
  logic             host_push, host_pop, seq_push, seq_pop;
  logic             und_ev, ovr_ev, seq_done;
  logic             f_empty, f_full;
  logic             req;

  assign in_exec   = (phase_q == PH_EXEC) && !exec_start;
  assign owed      = (host_cnt < len_q);
  assign host_push = in_exec && dir_q && host_wr && !f_full && !und_q && owed;
  assign host_pop  = in_exec && !dir_q && host_rd && !f_empty;

  fdc_xfer_ram_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (exec_start),
    .push  (host_push | seq_push),
    .pop   (host_pop | seq_pop),
    .wdata (dir_q ? host_wdata : disk_idata),
    .rdata (host_rdata),
    .count (fifo_level),
    .empty (f_empty),
    .full  (f_full)
  );

  fdc_disk_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (exec_start),
    .is_write   (xfer_write),
    .len        (sector_len),
    .need       (disk_need),
    .ivalid     (disk_ivalid),
    .fifo_empty (f_empty),
    .fifo_full  (f_full),
    .fifo_head  (host_rdata),
    .pop        (seq_pop),
    .push       (seq_push),
    .und_ev     (und_ev),
    .ovr_ev     (ovr_ev),
    .done       (seq_done),
    .odata      (disk_odata),
    .ovalid     (disk_ovalid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_CMD;
      dir_q    <= 1'b0;
      len_q    <= '0;
      host_cnt <= '0;
      und_q    <= 1'b0;
      ovr_q    <= 1'b0;
    end else if (exec_start) begin
      phase_q  <= PH_EXEC;
      dir_q    <= xfer_write;
      len_q    <= sector_len;
      host_cnt <= '0;
      und_q    <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (host_push) host_cnt <= host_cnt + 1'b1;
      if (und_ev)    und_q    <= 1'b1;
      if (ovr_ev)    ovr_q    <= 1'b1;
      case (phase_q)
        PH_EXEC:   if (seq_done && f_empty) phase_q <= PH_RESULT;
        PH_RESULT: if (result_done)         phase_q <= PH_CMD;
        default: ;
      endcase
    end
  end

  always_comb begin
    req = 1'b0;
    if (phase_q == PH_EXEC) begin
      if (dir_q) req = !und_q && owed && (fifo_level <= {1'b0, req_thresh});
      else       req = (fifo_level > {1'b0, req_thresh}) || (seq_done && !f_empty);
    end
  end

  assign host_req      = req && !dma_mode;
  assign dma_req       = req && dma_mode;
  assign phase         = phase_q;
  assign overrun_flag  = ovr_q;
  assign underrun_flag = und_q;

  // Width alignment helper kept local to the top.
  logic [CW-1:0] depth_c;
  assign depth_c = CW'(DEPTH);
  logic level_ok;
  assign level_ok = (fifo_level <= depth_c);
endmodule

// File: rtl/fdc_xfer_chk.sv
module fdc_xfer_chk
  import fdc_xfer_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   exec_start,
  input logic                   dma_mode,
  input logic                   host_req,
  input logic                   dma_req,
  input logic                   disk_ovalid,
  input logic [1:0]             phase,
  input logic                   overrun_flag,
  input logic                   underrun_flag,
  input logic [$clog2(DEPTH):0] fifo_level,
  input logic                   ovr_ev,
  input logic                   host_pop
);
  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(DEPTH)+1)'(DEPTH));

  // R2
  cmd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_CMD |-> fifo_level == '0);

  // R3
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> (fifo_level == '0) && (phase == PH_EXEC) && !overrun_flag && !underrun_flag);

  // R9
  result_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_RESULT |-> fifo_level == '0);

  // R6
  und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_flag && !exec_start |=> underrun_flag);

  // R7
  ovr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev && !host_pop && !exec_start |=> fifo_level == $past(fifo_level));

  // R10
  req_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req || dma_req) |-> phase == PH_EXEC);

  // R10
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_mode |-> !dma_req);

  // R4
  ovalid_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disk_ovalid |-> phase == PH_EXEC);
endmodule

bind fdc_xfer_fifo fdc_xfer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .exec_start    (exec_start),
  .dma_mode      (dma_mode),
  .host_req      (host_req),
  .dma_req       (dma_req),
  .disk_ovalid   (disk_ovalid),
  .phase         (phase),
  .overrun_flag  (overrun_flag),
  .underrun_flag (underrun_flag),
  .fifo_level    (fifo_level),
  .ovr_ev        (ovr_ev),
  .host_pop      (host_pop)
);

// File: tb/tb_fdc_xfer_fifo.sv
module tb_fdc_xfer_fifo;
  localparam int DEPTH = 16;
  localparam int LEN_W = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, exec_start, xfer_write, dma_mode, result_done;
  logic [3:0]       req_thresh;
  logic [LEN_W-1:0] sector_len;
  logic             host_wr, host_rd, disk_need, disk_ivalid;
  logic [7:0]       host_wdata, disk_idata, host_rdata, disk_odata;
  logic             host_req, dma_req, disk_ovalid, overrun_flag, underrun_flag;
  logic [1:0]       phase;
  logic [4:0]       fifo_level;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] rq[$];

  fdc_xfer_fifo #(.DEPTH(DEPTH), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .exec_start(exec_start), .xfer_write(xfer_write),
    .dma_mode(dma_mode), .req_thresh(req_thresh), .sector_len(sector_len),
    .result_done(result_done), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_req(host_req), .dma_req(dma_req),
    .disk_need(disk_need), .disk_odata(disk_odata), .disk_ovalid(disk_ovalid),
    .disk_ivalid(disk_ivalid), .disk_idata(disk_idata), .phase(phase),
    .overrun_flag(overrun_flag), .underrun_flag(underrun_flag), .fifo_level(fifo_level)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Bitwise CRC-16 (0x1021), feedback form.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic start_exec(input logic w, input int len);
    exec_start = 1'b1; xfer_write = w; sector_len = LEN_W'(len);
    step();
    exec_start = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] b);
    host_wr = 1'b1; host_wdata = b;
    step();
    host_wr = 1'b0;
  endtask

  task automatic host_read(output logic [7:0] b);
    b = host_rdata;
    host_rd = 1'b1;
    step();
    host_rd = 1'b0;
  endtask

  task automatic need_byte(output logic [7:0] b, output logic v);
    disk_need = 1'b1;
    step();
    b = disk_odata; v = disk_ovalid;
    disk_need = 1'b0;
  endtask

  task automatic disk_byte(input logic [7:0] b);
    disk_ivalid = 1'b1; disk_idata = b;
    step();
    disk_ivalid = 1'b0;
  endtask

  task automatic finish_result();
    result_done = 1'b1;
    step();
    result_done = 1'b0;
    chk("R9 back to command", phase, 0);
  endtask

  task automatic run_write(input int len, input int nhost);
    logic [7:0] d[$];
    logic [7:0] b, e;
    logic       v;
    logic [15:0] crc;
    int widx;
    start_exec(1'b1, len);
    chk("R3 flushed level", fifo_level, 0);
    for (int i = 0; i < nhost; i++) d.push_back(8'($urandom));
    widx = 0;
    while (widx < nhost && widx < DEPTH) begin host_write(d[widx]); widx++; end
    crc = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      need_byte(b, v);
      e = (i < nhost) ? d[i] : 8'h00;
      chk(i < nhost ? "R4 data byte" : "R6 pad byte", b, e);
      chk("R4 ovalid", v, 1);
      crc = ref_crc(crc, e);
      if (widx < nhost) begin host_write(d[widx]); widx++; end
    end
    need_byte(b, v);
    chk("R5 crc high", {v, b}, {1'b1, crc[15:8]});
    need_byte(b, v);
    chk("R5 crc low", {v, b}, {1'b1, crc[7:0]});
    step();
    chk("R9 result after write", phase, 2);
    chk("R6 underrun flag", underrun_flag, (nhost < len) ? 1 : 0);
    finish_result();
  endtask

  task automatic drain_one();
    logic [7:0] b;
    host_read(b);
    chk("R8 drained byte", b, rq.pop_front());
  endtask

  task automatic run_read(input int len);
    logic [7:0] x;
    rq.delete();
    start_exec(1'b0, len);
    for (int i = 0; i < len; i++) begin
      if (fifo_level == 5'(DEPTH)) drain_one();
      x = 8'($urandom);
      disk_byte(x);
      rq.push_back(x);
      if ($urandom % 2 == 1 && fifo_level != 0) drain_one();
    end
    if (rq.size() > 0) begin
      step();
      chk("R9 waits for drain", phase, 1);
    end
    while (rq.size() > 0) drain_one();
    step();
    chk("R9 result after read", phase, 2);
    chk("R7 no overrun", overrun_flag, 0);
    finish_result();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic       v;
    logic [15:0] crc;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; exec_start = 1'b0; xfer_write = 1'b0; dma_mode = 1'b0;
    result_done = 1'b0; req_thresh = 4'd0; sector_len = '0;
    host_wr = 1'b0; host_rd = 1'b0; disk_need = 1'b0; disk_ivalid = 1'b0;
    host_wdata = '0; disk_idata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 phase", phase, 0);
    chk("R1 flags", {overrun_flag, underrun_flag}, 0);
    chk("R1 level", fifo_level, 0);
    chk("R1 requests", {host_req, dma_req, disk_ovalid}, 0);

    // R2 command phase ignores traffic
    host_write(8'h5A);
    disk_byte(8'hA5);
    chk("R2 level in command", fifo_level, 0);
    chk("R2 phase", phase, 0);

    // R3 flush of stale bytes on restart
    start_exec(1'b0, 10);
    for (int i = 0; i < 5; i++) disk_byte(8'(i + 1));
    chk("R3 stale bytes held", fifo_level, 5);
    start_exec(1'b1, 8);
    chk("R3 flush on exec", fifo_level, 0);
    chk("R3 phase exec", phase, 1);

    // R10 thresholds and request line select
    req_thresh = 4'd4;
    start_exec(1'b1, 30);
    chk("R10 write req low level", {host_req, dma_req}, 2'b10);
    for (int i = 0; i < 5; i++) host_write(8'(i));
    chk("R10 write req above thresh", {host_req, dma_req}, 2'b00);
    dma_mode = 1'b1;
    need_byte(b, v);
    chk("R10 dma req at thresh", {host_req, dma_req}, 2'b01);
    dma_mode = 1'b0;
    req_thresh = 4'd2;
    start_exec(1'b0, 3);
    disk_byte(8'h11); disk_byte(8'h22);
    chk("R10 read req at thresh", host_req, 0);
    disk_byte(8'h33);
    chk("R10 read req above thresh", host_req, 1);
    host_read(b); host_read(b);
    chk("R10 read req drain tail", host_req, 1);
    chk("R8 tail byte", host_rdata, 8'h33);
    host_read(b);
    step();
    chk("R9 read result", phase, 2);
    chk("R10 no req in result", {host_req, dma_req}, 0);
    finish_result();

    // R6 underrun with ignored host write
    start_exec(1'b1, 4);
    need_byte(b, v);
    chk("R6 first pad", {v, b}, {1'b1, 8'h00});
    chk("R6 flag set", underrun_flag, 1);
    host_write(8'hEE);
    chk("R6 host write ignored", fifo_level, 0);
    crc = ref_crc(16'hFFFF, 8'h00);
    for (int i = 0; i < 3; i++) begin
      need_byte(b, v);
      chk("R6 pad byte", b, 0);
      crc = ref_crc(crc, 8'h00);
    end
    need_byte(b, v);
    chk("R5 pad crc high", b, crc[15:8]);
    need_byte(b, v);
    chk("R5 pad crc low", b, crc[7:0]);
    step();
    chk("R9 result after pad", phase, 2);
    finish_result();

    // R7 overrun on a full FIFO
    rq.delete();
    start_exec(1'b0, 20);
    for (int i = 0; i < DEPTH; i++) begin
      b = 8'($urandom);
      disk_byte(b);
      rq.push_back(b);
    end
    chk("R7 no overrun yet", overrun_flag, 0);
    disk_byte(8'hC3);
    chk("R7 overrun flag", overrun_flag, 1);
    chk("R7 level held", fifo_level, DEPTH);
    disk_byte(8'h3C);
    chk("R7 later byte dropped", fifo_level, DEPTH);
    chk("R8 still exec before drain", phase, 1);
    while (rq.size() > 0) drain_one();
    step();
    chk("R9 result after overrun drain", phase, 2);
    chk("R9 flag holds in result", overrun_flag, 1);
    start_exec(1'b1, 2);
    chk("R3 flags cleared", {overrun_flag, underrun_flag}, 0);

    // Random sectors
    req_thresh = 4'd8;
    for (int k = 0; k < 12; k++) begin
      int len;
      len = 1 + int'($urandom % 40);
      run_write(len, int'($urandom % (len + 1)));
    end
    run_write(20, 20);
    run_write(1, 0);
    for (int k = 0; k < 12; k++) run_read(1 + int'($urandom % 40));

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule